// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive and brings it up after reset. Coming out of reset it keeps the strobes idle for a parameterised power-on pause. It then runs a fixed number of wake-up RAS cycles on its own. Only after those cycles does it tell the access controller, through `init_done`, that normal traffic may begin. From then on a divider produces one refresh obligation per refresh interval. Obligations that are not yet served are held as debt. While any debt is owed, the sequencer raises `ref_req`. When the access controller answers with `ref_gnt`, the sequencer takes over the RAS and CAS lines for one refresh cycle and shows that it owns them on `ref_active`.

Each refresh cycle is normally a CAS-before-RAS cycle, in which the DRAM supplies the row from its own counter. The sequencer never drives the address bus in that cycle. If `row_mode` is high when a cycle starts, the cycle is instead a RAS-only refresh. It then drives a row from an internal counter onto `row_addr`, qualified by `row_addr_en`, and steps that counter after the cycle. The debt is allowed to reach a parameterised ceiling. A further interval with the ceiling still full is treated as a missed refresh period: `backlog_err` pulses, `init_done` drops, and the wake-up cycles are run again, this time only as they are granted. Clock frequency and all timing values are parameters given in nanoseconds and rounded up to whole clock cycles.

The controller is one state machine:
- **PAUSE**: power-on wait. It leaves for IDLE when the pause timer expires.
- **IDLE**: strobes high. It starts a cycle when one is due and is allowed. It goes to CSR for CAS-before-RAS, or straight to RAS for RAS-only.
- **CSR**: CAS low, RAS high, for the setup time. Then it goes to HOLD.
- **HOLD**: both strobes low for the CAS hold time. Then it goes to RAS.
- **RAS**: RAS low with CAS high until the RAS pulse width is met. Then it goes to PRE.
- **PRE**: both strobes high for the precharge time. Then it returns to IDLE.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted: `ras_n` and `cas_n` are 1; `init_done`, `ref_req`, `ref_active`, `backlog_err` and `row_addr_en` are 0; the RAS-only row counter reads 0.
- R2: For the first PAUSE_CYC cycles after reset is released, both strobes stay high and `ref_req` stays 0. The first wake-up cycle begins on the next cycle without waiting for a grant, so the first strobe falls PAUSE_CYC+1 cycles after release.
- R3: `init_done` rises on the cycle in which the WAKE_CNT-th wake-up cycle leaves precharge, and not before.
- R4: In a CAS-before-RAS cycle, `cas_n` is 0 for TCSR_CYC cycles with `ras_n` at 1. Both are then 0 for TCHR_CYC cycles. `ras_n` stays 0 for TRAS_CYC cycles in total, followed by TRP_CYC cycles with both strobes at 1.
- R5: During a CAS-before-RAS cycle `row_addr_en` stays 0, so the address bus is left to the access controller.
- R6: One refresh becomes owed every REF_CYC cycles while `init_done` is 1. The first owed refresh raises `ref_req` exactly REF_CYC cycles after `init_done` rises. In IDLE, `ref_req` is 1 whenever a refresh is owed.
- R7: A refresh cycle starts only in the cycle after `ref_gnt` is sampled at 1 in IDLE with `ref_req` at 1. `ref_req` is 0 whenever `ref_active` is 1.
- R8: Up to MAX_OWED refreshes may be owed. When a new one becomes due with MAX_OWED already owed and none starting, the debt is cleared, `backlog_err` is 1 for exactly one cycle, `init_done` falls in that same cycle, and WAKE_CNT wake-up cycles become pending. Those pending cycles raise `ref_req` and run only as they are granted.
- R9: A cycle started with `row_mode` at 1 is RAS-only: `cas_n` stays 1, `ras_n` is 0 for TRAS_CYC cycles, and `row_addr_en` is 1 exactly while `ras_n` is 0. `row_addr` shows the counter, which begins at 0, advances by 1 as RAS rises, and wraps modulo 2^ROW_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_mode | input | 1 | 1 selects RAS-only refresh for the cycle about to start |
| ref_gnt | input | 1 | Access controller yields the DRAM lines |
| ref_req | output | 1 | A refresh or re-wake cycle is waiting for a grant |
| ref_active | output | 1 | Sequencer owns the strobes (setup, strobe or precharge phase) |
| init_done | output | 1 | Power-up sequence complete; normal access allowed |
| backlog_err | output | 1 | One-cycle pulse: refresh debt overflowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_W | Row counter for RAS-only refresh |
| row_addr_en | output | 1 | Sequencer drives `row_addr` onto the address bus |

## Verification
The bench builds the block at 125 MHz with a 320 ns pause (40 cycles), a 240 ns interval (30 cycles) and strobe times of 16, 24, 48 and 32 ns, which give 2, 3, 6 and 4 cycles. These timings make two complete power-up sequences and a nine-interval debt overflow fit into a few thousand cycles, and every phase length is a distinct count that can be checked separately. ROW_W is set to 3, so the eight RAS-only wake-up cycles after a second reset wrap the row counter. The following RAS-only refresh must then drive row 0 again.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE = 3'd0,
        ST_IDLE  = 3'd1,
        ST_CSR   = 3'd2,
        ST_HOLD  = 3'd3,
        ST_RAS   = 3'd4,
        ST_PRE   = 3'd5
    } rfs_state_e;

    // Round a duration in ns up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
    parameter int PERIOD = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(PERIOD - 1));
    assign tick = en && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!en)    cnt <= '0;
        else if (last)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rfs_debt_ctr.sv
module rfs_debt_ctr #(
    parameter int MAX_OWED = 8,
    localparam int OW = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          take,
    output logic [OW-1:0] owed,
    output logic          ovf_now,
    output logic          err_q
);
    assign ovf_now = tick && !take && (owed == OW'(MAX_OWED));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed  <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= ovf_now;
            if (ovf_now)             owed <= '0;
            else if (tick && !take)  owed <= owed + 1'b1;
            else if (take && !tick)  owed <= owed - 1'b1;
        end
    end
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   row <= '0;
        else if (inc) row <= row + 1'b1;
    end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import rfs_pkg::*;
#(
    parameter int CLK_MHZ  = 125,
    parameter int PAUSE_NS = 200000,
    parameter int REF_NS   = 15600,
    parameter int TCSR_NS  = 10,
    parameter int TCHR_NS  = 10,
    parameter int TRAS_NS  = 60,
    parameter int TRP_NS   = 40,
    parameter int WAKE_CNT = 8,
    parameter int MAX_OWED = 8,
    parameter int ROW_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_mode,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             ref_active,
    output logic             init_done,
    output logic             backlog_err,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             row_addr_en
);
    localparam int PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_MHZ);
    localparam int REF_CYC   = ns_to_cyc(REF_NS, CLK_MHZ);
    localparam int TCSR_CYC  = ns_to_cyc(TCSR_NS, CLK_MHZ);
    localparam int TCHR_CYC  = ns_to_cyc(TCHR_NS, CLK_MHZ);
    localparam int TRAS_CYC  = max2(ns_to_cyc(TRAS_NS, CLK_MHZ), TCHR_CYC + 1);
    localparam int TRP_CYC   = ns_to_cyc(TRP_NS, CLK_MHZ);
    localparam int RASB_CYC  = TRAS_CYC - TCHR_CYC;
    localparam int TMR_MAX   = max2(max2(PAUSE_CYC, TRAS_CYC),
                                    max2(TRP_CYC, max2(TCSR_CYC, TCHR_CYC)));
    localparam int TMR_W     = $clog2(TMR_MAX + 1);
    localparam int WAKE_W    = $clog2(WAKE_CNT + 1);
    localparam int OWE_W     = $clog2(MAX_OWED + 1);

    rfs_state_e        state, nxt_state;
    logic [TMR_W-1:0]  tmr, nxt_tmr;
    logic [WAKE_W-1:0] wake_left;
    logic              boot, init_q, cyc_ro, cyc_wake;
    logic [OWE_W-1:0]  owed;
    logic              tick, ovf, tmr_zero;
    logic              start_norm, start_wake, start, wake_step, row_inc;

    // ---------------- sub-blocks ----------------
    rfs_tick_gen #(.PERIOD(REF_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(init_q), .tick(tick)
    );

    rfs_debt_ctr #(.MAX_OWED(MAX_OWED)) u_debt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .take(start_norm),
        .owed(owed), .ovf_now(ovf), .err_q(backlog_err)
    );

    rfs_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .inc(row_inc), .row(row_addr)
    );

    // ---------------- decisions ----------------
    assign tmr_zero   = (tmr == '0);
    assign start_wake = (state == ST_IDLE) && (wake_left != '0) && (boot || ref_gnt);
    assign start_norm = (state == ST_IDLE) && (wake_left == '0) && (owed != '0) && ref_gnt;
    assign start      = start_wake || start_norm;
    assign wake_step  = (state == ST_PRE) && tmr_zero && cyc_wake;
    assign row_inc    = (state == ST_RAS) && tmr_zero && cyc_ro;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_PAUSE;
            tmr       <= TMR_W'(PAUSE_CYC - 1);
            wake_left <= WAKE_W'(WAKE_CNT);
            boot      <= 1'b1;
            init_q    <= 1'b0;
            cyc_ro    <= 1'b0;
            cyc_wake  <= 1'b0;
        end else begin
            state <= nxt_state;
            tmr   <= nxt_tmr;
            if (start) begin
                cyc_ro   <= row_mode;
                cyc_wake <= (wake_left != '0);
            end
            if (ovf) begin
                wake_left <= WAKE_W'(WAKE_CNT);
                init_q    <= 1'b0;
            end else if (wake_step) begin
                wake_left <= wake_left - 1'b1;
                if (wake_left == WAKE_W'(1)) begin
                    init_q <= 1'b1;
                    boot   <= 1'b0;
                end
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt_state = state;
        nxt_tmr   = tmr_zero ? tmr : tmr - 1'b1;
        unique case (state)
            ST_PAUSE: begin
                if (tmr_zero) nxt_state = ST_IDLE;
            end
            ST_IDLE: begin
                if (start) begin
                    if (row_mode) begin
                        nxt_state = ST_RAS;
                        nxt_tmr   = TMR_W'(TRAS_CYC - 1);
                    end else begin
                        nxt_state = ST_CSR;
                        nxt_tmr   = TMR_W'(TCSR_CYC - 1);
                    end
                end
            end
            ST_CSR: begin
                if (tmr_zero) begin
                    nxt_state = ST_HOLD;
                    nxt_tmr   = TMR_W'(TCHR_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    nxt_state = ST_RAS;
                    nxt_tmr   = TMR_W'(RASB_CYC - 1);
                end
            end
            ST_RAS: begin
                if (tmr_zero) begin
                    nxt_state = ST_PRE;
                    nxt_tmr   = TMR_W'(TRP_CYC - 1);
                end
            end
            ST_PRE: begin
                if (tmr_zero) nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        ras_n       = !((state == ST_HOLD) || (state == ST_RAS));
        cas_n       = !((state == ST_CSR) || (state == ST_HOLD));
        ref_active  = (state == ST_CSR) || (state == ST_HOLD) ||
                      (state == ST_RAS) || (state == ST_PRE);
        row_addr_en = (state == ST_RAS) && cyc_ro;
        ref_req     = (state == ST_IDLE) &&
                      (((wake_left == '0) && (owed != '0)) ||
                       ((wake_left != '0) && !boot));
        init_done   = init_q;
    end
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
    parameter int PAUSE_CYC = 40,
    parameter int TRAS_CYC  = 6,
    parameter int TRP_CYC   = 4,
    parameter int ROW_W     = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             row_addr_en,
    input logic [ROW_W-1:0] row_addr,
    input logic             ref_req,
    input logic             ref_active,
    input logic             init_done,
    input logic             backlog_err
);
    int          since_rst;
    logic [15:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 0;
            lo_cnt    <= '0;
            hi_cnt    <= '0;
        end else begin
            if (since_rst < PAUSE_CYC) since_rst <= since_rst + 1;
            if (!ras_n) begin
                hi_cnt <= '0;
                if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
            end else begin
                lo_cnt <= '0;
                if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < PAUSE_CYC) |-> (ras_n && cas_n && !ref_req)); // R2
    AST_CBR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !row_addr_en) |-> (!cas_n && !$past(cas_n))); // R4
    AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (int'(lo_cnt) >= TRAS_CYC)); // R4
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (int'(hi_cnt) >= TRP_CYC)); // R4
    AST_CBR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !row_addr_en); // R5
    AST_REQ_OFF_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_active |-> !ref_req); // R7
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        backlog_err |=> !backlog_err); // R8
    AST_ERR_INIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        backlog_err |-> !init_done); // R8
    AST_RO_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        row_addr_en |-> (cas_n && !ras_n)); // R9
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && $past(row_addr_en)) |->
            (row_addr == ROW_W'($past(row_addr) + 1'b1))); // R9
endmodule

bind dram_refresh_seq rfs_checker #(
    .PAUSE_CYC(PAUSE_CYC), .TRAS_CYC(TRAS_CYC), .TRP_CYC(TRP_CYC), .ROW_W(ROW_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .row_addr_en(row_addr_en), .row_addr(row_addr), .ref_req(ref_req),
    .ref_active(ref_active), .init_done(init_done), .backlog_err(backlog_err)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
    // 125 MHz clock: 8 ns period. Expected cycle counts worked out by hand:
    // pause 320ns=40, interval 240ns=30, setup 16ns=2, hold 24ns=3,
    // RAS width 48ns=6, precharge 32ns=4.
    localparam int P_CYC = 40, REF_C = 30, CSR_C = 2, CHR_C = 3, RAS_C = 6, RP_C = 4;
    localparam int ROWS = 8;

    logic       clk = 1'b0;
    logic       rst_n, row_mode, ref_gnt;
    logic       ref_req, ref_active, init_done, backlog_err, ras_n, cas_n, row_addr_en;
    logic [2:0] row_addr;

    always #4 clk = ~clk;

    dram_refresh_seq #(
        .CLK_MHZ(125), .PAUSE_NS(320), .REF_NS(240), .TCSR_NS(16), .TCHR_NS(24),
        .TRAS_NS(48), .TRP_NS(32), .WAKE_CNT(8), .MAX_OWED(8), .ROW_W(3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .row_mode(row_mode), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .ref_active(ref_active), .init_done(init_done),
        .backlog_err(backlog_err), .ras_n(ras_n), .cas_n(cas_n),
        .row_addr(row_addr), .row_addr_en(row_addr_en)
    );

    int checks = 0, fails = 0, row_model = 0;
    bit finished = 1'b0;

    // {row_mode, grant delay, exp setup, exp hold, exp ras-low, exp precharge}
    localparam logic [19:0] VEC [0:5] = '{
        {1'b0, 3'd0, 4'd2, 4'd3, 4'd6, 4'd4},
        {1'b1, 3'd0, 4'd0, 4'd0, 4'd6, 4'd4},
        {1'b0, 3'd3, 4'd2, 4'd3, 4'd6, 4'd4},
        {1'b1, 3'd2, 4'd0, 4'd0, 4'd6, 4'd4},
        {1'b1, 3'd5, 4'd0, 4'd0, 4'd6, 4'd4},
        {1'b0, 3'd1, 4'd2, 4'd3, 4'd6, 4'd4}
    };

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Wait for a request, hold off the grant, grant, then measure the cycle.
    task automatic do_refresh(input bit mode, input int delay, input int e_csr,
                              input int e_hold, input int e_lo, input int e_pre);
        int csr = 0, hold = 0, lo = 0, pre = 0, guard = 0;
        int early = 0, bad_req = 0, bad_addr = 0, bad_en = 0, cas_in_ro = 0;
        row_mode = mode;
        while (!ref_req && guard < 200) begin step(); guard++; end
        chk_eq("R6", "request pending before grant", int'(ref_req), 1);
        for (int i = 0; i < delay; i++) begin
            step();
            if (!ras_n || ref_active) early++;
        end
        chk_eq("R7", "no cycle without grant", early, 0);
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        chk_eq("R7", "cycle starts after grant", int'(ref_active), 1);
        guard = 0;
        while (ref_active && guard < 40) begin
            if (ras_n && !cas_n)  csr++;
            if (!ras_n && !cas_n) hold++;
            if (!ras_n)           lo++;
            if (ras_n && cas_n)   pre++;
            if (ref_req)          bad_req++;
            if (mode) begin
                if (!cas_n) cas_in_ro++;
                if (row_addr_en != !ras_n) bad_en++;
                if (!ras_n && int'(row_addr) != row_model) bad_addr++;
            end else if (row_addr_en) begin
                bad_en++;
            end
            step();
            guard++;
        end
        chk_eq(mode ? "R9" : "R4", "setup cycles", csr, e_csr);
        chk_eq(mode ? "R9" : "R4", "cas hold cycles", hold, e_hold);
        chk_eq(mode ? "R9" : "R4", "ras low cycles", lo, e_lo);
        chk_eq("R4", "precharge cycles", pre, e_pre);
        chk_eq("R7", "request low while active", bad_req, 0);
        if (mode) begin
            chk_eq("R9", "cas low in ras-only", cas_in_ro, 0);
            chk_eq("R9", "row enable mismatch", bad_en, 0);
            chk_eq("R9", "row address mismatch", bad_addr, 0);
            row_model = (row_model + 1) % ROWS;
        end else begin
            chk_eq("R5", "address driven in cbr", bad_en, 0);
        end
    endtask

    task automatic boot_run(output int first_cas, output int first_ras, output int falls,
                            output int init_at, output int req_seen,
                            output int ras_addr, output int ras_en, output int ras_cas);
        logic prev = 1'b1;
        first_cas = -1; first_ras = -1; falls = 0; init_at = -1; req_seen = 0;
        ras_addr = -1; ras_en = -1; ras_cas = -1;
        for (int n = 1; n <= 400; n++) begin
            step();
            if (ref_req) req_seen++;
            if (!cas_n && first_cas < 0) first_cas = n;
            if (!ras_n && first_ras < 0) begin
                first_ras = n;
                ras_addr  = int'(row_addr);
                ras_en    = int'(row_addr_en);
                ras_cas   = int'(cas_n);
            end
            if (prev && !ras_n && !init_done) falls++;
            prev = ras_n;
            if (init_done) begin init_at = n; break; end
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        int fc, fr, fl, ia, rq, ra, re, rc, guard;
        bit err_early, init_lost, ras_moved;
        rst_n = 1'b0; ref_gnt = 1'b0; row_mode = 1'b0;
        repeat (3) step();
        // R1 reset state
        chk_eq("R1", "ras_n in reset", int'(ras_n), 1);
        chk_eq("R1", "cas_n in reset", int'(cas_n), 1);
        chk_eq("R1", "init_done in reset", int'(init_done), 0);
        chk_eq("R1", "ref_req in reset", int'(ref_req), 0);
        chk_eq("R1", "ref_active in reset", int'(ref_active), 0);
        chk_eq("R1", "backlog_err in reset", int'(backlog_err), 0);
        chk_eq("R1", "row counter in reset", int'(row_addr), 0);
        rst_n = 1'b1;

        // R2/R3 power-up with CAS-before-RAS wake cycles
        boot_run(fc, fr, fl, ia, rq, ra, re, rc);
        chk_eq("R2", "first cas low cycle", fc, P_CYC + 1);
        chk_eq("R2", "no request during power-up", rq, 0);
        chk_eq("R4", "first ras low cycle", fr, P_CYC + 1 + CSR_C);
        chk_eq("R3", "wake cycles before init", fl, 8);
        chk_eq("R3", "init_done cycle", ia,
               P_CYC + 1 + 7 * (CSR_C + RAS_C + RP_C + 1) + CSR_C + RAS_C + RP_C - 1 + 1);

        // R6 first refresh becomes owed one interval after init
        for (int n = 1; n <= REF_C; n++) begin
            step();
            if (n == REF_C - 1) chk_eq("R6", "no request before interval", int'(ref_req), 0);
            if (n == REF_C)     chk_eq("R6", "request at interval", int'(ref_req), 1);
        end

        // table walk over modes and grant delays
        for (int i = 0; i < 6; i++) begin
            do_refresh(VEC[i][19], int'(VEC[i][18:16]), int'(VEC[i][15:12]),
                       int'(VEC[i][11:8]), int'(VEC[i][7:4]), int'(VEC[i][3:0]));
        end

        // drain the debt
        guard = 0;
        while (ref_req && guard < 20) begin
            do_refresh(1'b0, 0, CSR_C, CHR_C, RAS_C, RP_C);
            guard++;
        end
        chk_eq("R6", "debt drained", int'(ref_req), 0);

        // R8 overflow: first new obligation, then eight more ungranted intervals
        guard = 0;
        while (!ref_req && guard < 40) begin step(); guard++; end
        err_early = 1'b0; init_lost = 1'b0;
        for (int k = 1; k < 8 * REF_C; k++) begin
            step();
            if (backlog_err) err_early = 1'b1;
            if (!init_done)  init_lost = 1'b1;
        end
        chk_eq("R8", "no error while debt within limit", int'(err_early), 0);
        chk_eq("R8", "init kept while debt within limit", int'(init_lost), 0);
        step();
        chk_eq("R8", "backlog_err on overflow", int'(backlog_err), 1);
        chk_eq("R8", "init_done falls on overflow", int'(init_done), 0);
        step();
        chk_eq("R8", "backlog_err is one cycle", int'(backlog_err), 0);
        chk_eq("R8", "re-wake requests grant", int'(ref_req), 1);
        ras_moved = 1'b0;
        for (int k = 0; k < 20; k++) begin
            step();
            if (!ras_n || !cas_n) ras_moved = 1'b1;
        end
        chk_eq("R8", "no re-wake cycle without grant", int'(ras_moved), 0);
        for (int w = 0; w < 8; w++) begin
            do_refresh(1'b0, 0, CSR_C, CHR_C, RAS_C, RP_C);
            chk_eq("R3", "init_done after re-wake cycle", int'(init_done), (w == 7) ? 1 : 0);
        end

        // second reset, power-up in RAS-only mode, row counter wrap
        row_mode = 1'b1;
        rst_n = 1'b0;
        step(); step();
        chk_eq("R1", "row counter cleared by reset", int'(row_addr), 0);
        chk_eq("R1", "init_done cleared by reset", int'(init_done), 0);
        rst_n = 1'b1;
        boot_run(fc, fr, fl, ia, rq, ra, re, rc);
        chk_eq("R9", "ras-only first ras low cycle", fr, P_CYC + 1);
        chk_eq("R9", "ras-only first row", ra, 0);
        chk_eq("R9", "ras-only address enabled", re, 1);
        chk_eq("R9", "ras-only cas stays high", rc, 1);
        chk_eq("R3", "ras-only wake cycles", fl, 8);
        row_model = 0;  // eight wake rows 0..7 wrap a 3-bit counter
        do_refresh(1'b1, 0, 0, 0, RAS_C, RP_C);
        summary();
    end
endmodule